// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to `NUM_SRC` system interrupt lines and folds them into one host interrupt request. Each line passes through a two-flop synchronizer. Per-line polarity and type bits decide whether a line latches its status bit on a transition or follows a level. A latched status bit becomes a candidate once its enable bit is also set. Among the candidates, the one whose assigned channel has the smallest number wins. When two candidates share a channel, the smaller line number wins.

Software reaches the block over a plain 32-bit register port, where a request is one cycle of `bus_valid`. It has no back-pressure: every request is accepted in the cycle it is presented. Read data returns one cycle later, qualified by `bus_rvalid`. Status and enable bits can be changed one line at a time by writing the line number to an index register, or many at once through bitmask registers. A handler reads the prioritized-index register to learn which line to service. That register also carries a flag for when nothing is pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register is zero, `host_irq` is 0 and the prioritized-index register (0x080) reads 0x8000_0000.
- R2: Polarity words at 0xD00+4n and type words at 0xD80+4n are read/write with one bit per line, where bit b covers line 32n+b. Type 1 selects edge sensing and type 0 selects level sensing. Polarity 1 selects rising or active-high, and polarity 0 selects falling or active-low.
- R3: A level-type line sets its status bit two synchronizer cycles after reaching its active level. A status clear has no effect while that level persists.
- R4: An edge-type line sets its status bit on the selected transition. The bit stays set after the line returns to its idle level.
- R5: Writing a line number in bits 9:0 to 0x024 clears only that line's status bit. A number of `NUM_SRC` or more changes nothing.
- R6: Writing a line number to 0x028 sets that line's enable bit, and writing it to 0x02C clears it.
- R7: A write to 0x280+4n clears status bits and a write to 0x380+4n clears enable bits, for lines 32n..32n+31. A 1 bit clears the bit and a 0 bit keeps it. Reads of these words return the current status and enable bits.
- R8: Channel words at 0x400+4n are read/write. Byte k holds the channel number of line 4n+k.
- R9: Register 0x080 returns the winning candidate (status and enable both 1) in bits 9:0. The winner has the lowest channel, and ties go to the lowest line number. Bit 31 is set when no candidate exists.
- R10: `host_irq` is 1 exactly when the global enable (0x010 bit 0) is 1, host enable bit 1 is 1, and a candidate exists.
- R11: Writing host index 1 to 0x034 sets host enable bit 1, and writing it to 0x038 clears it. The host enable word at 0x1500 is read/write in bits 1:0.
- R12: `bus_rvalid` pulses one cycle after each read. The index registers and unmapped offsets read 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw system interrupt lines |
| bus_valid | input | 1 | Register request strobe, one cycle per request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| host_irq | output | 1 | Active-high host interrupt request |

## Verification
The assertions assume that register requests arrive only after reset is released and only at word-aligned offsets. They also assume that a line being watched for an edge is not reconfigured in the same window as its transition. The stimulus changes lines and bus signals only on falling clock edges. It holds every line level for at least four cycles so that the synchronizer always sees a settled value. Polarity and type are programmed before the lines under test move, and status is cleared once after that setup, because the reset polarity makes idle low lines count as active.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 10;
  localparam int HOST_N  = 2;
  localparam int HOST_IRQ_BIT = 1;

  localparam logic [ADDR_W-1:0] OFS_GLB       = 13'h0010;
  localparam logic [ADDR_W-1:0] OFS_STAT_IDXC = 13'h0024;
  localparam logic [ADDR_W-1:0] OFS_EN_IDXS   = 13'h0028;
  localparam logic [ADDR_W-1:0] OFS_EN_IDXC   = 13'h002C;
  localparam logic [ADDR_W-1:0] OFS_HEN_IDXS  = 13'h0034;
  localparam logic [ADDR_W-1:0] OFS_HEN_IDXC  = 13'h0038;
  localparam logic [ADDR_W-1:0] OFS_WINNER    = 13'h0080;
  localparam logic [ADDR_W-1:0] OFS_STAT_MSK  = 13'h0280;
  localparam logic [ADDR_W-1:0] OFS_EN_MSK    = 13'h0380;
  localparam logic [ADDR_W-1:0] OFS_CHAN      = 13'h0400;
  localparam logic [ADDR_W-1:0] OFS_POL       = 13'h0D00;
  localparam logic [ADDR_W-1:0] OFS_KIND      = 13'h0D80;
  localparam logic [ADDR_W-1:0] OFS_HEN       = 13'h1500;

  function automatic logic [ADDR_W-1:0] word_at(input logic [ADDR_W-1:0] base, input int n);
    return base + ADDR_W'(4 * n);
  endfunction
endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] kind,
  output logic [NUM_SRC-1:0] set_vec
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    logic meta_q, sync_q, act_q, act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        meta_q <= src_in[i];
        sync_q <= meta_q;
        act_q  <= act;
      end
    end

    assign act        = (sync_q == pol[i]);
    assign set_vec[i] = kind[i] ? (act & ~act_q) : act;

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind[i] && set_vec[i]) |=> !(kind[i] && set_vec[i]));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int CHAN_W  = 8,
  parameter int IDX_W   = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              cand,
  input  logic [NUM_SRC-1:0][CHAN_W-1:0]  chan,
  output logic                            win_valid,
  output logic [IDX_W-1:0]                win_idx
);
  logic [CHAN_W-1:0] best_chan;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_chan = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!win_valid || chan[i] < best_chan)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best_chan = chan[i];
      end
    end
  end

  // R9
  win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_idx]);
  // R9
  none_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !win_valid);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int CHAN_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  output logic                            bus_rvalid,
  input  logic [NUM_SRC-1:0]              set_vec,
  input  logic                            win_valid,
  input  logic [IDX_W-1:0]                win_idx,
  output logic [NUM_SRC-1:0]              status,
  output logic [NUM_SRC-1:0]              enable,
  output logic [NUM_SRC-1:0]              pol,
  output logic [NUM_SRC-1:0]              kind,
  output logic [NUM_SRC-1:0][CHAN_W-1:0]  chan,
  output logic                            glb_en,
  output logic [HOST_N-1:0]               host_en
);
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int BIT_WORDS = NUM_SRC / 32;
  localparam int MAP_WORDS = NUM_SRC / 4;

  logic              wr, rd, idx_ok, hidx_ok;
  logic [SRC_W-1:0]  idx_lo;
  logic [NUM_SRC-1:0] stat_clr, en_set, en_clr;
  logic [DATA_W-1:0] rd_mux;

  assign wr      = bus_valid & bus_write;
  assign rd      = bus_valid & ~bus_write;
  assign idx_lo  = bus_wdata[SRC_W-1:0];
  assign idx_ok  = bus_wdata[IDX_W-1:0] < IDX_W'(NUM_SRC);
  assign hidx_ok = bus_wdata[IDX_W-1:0] == IDX_W'(HOST_IRQ_BIT);

  always_comb begin
    stat_clr = '0;
    en_set   = '0;
    en_clr   = '0;
    if (wr && idx_ok) begin
      if (bus_addr == OFS_STAT_IDXC) stat_clr[idx_lo] = 1'b1;
      if (bus_addr == OFS_EN_IDXS)   en_set[idx_lo]   = 1'b1;
      if (bus_addr == OFS_EN_IDXC)   en_clr[idx_lo]   = 1'b1;
    end
    for (int w = 0; w < BIT_WORDS; w++) begin
      if (wr && bus_addr == word_at(OFS_STAT_MSK, w)) stat_clr[32*w +: 32] = bus_wdata;
      if (wr && bus_addr == word_at(OFS_EN_MSK, w))   en_clr[32*w +: 32]   = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~stat_clr) | set_vec;
      enable <= (enable & ~en_clr) | en_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol     <= '0;
      kind    <= '0;
      chan    <= '0;
      glb_en  <= 1'b0;
      host_en <= '0;
    end else if (wr) begin
      for (int w = 0; w < BIT_WORDS; w++) begin
        if (bus_addr == word_at(OFS_POL, w))  pol[32*w +: 32]  <= bus_wdata;
        if (bus_addr == word_at(OFS_KIND, w)) kind[32*w +: 32] <= bus_wdata;
      end
      for (int m = 0; m < MAP_WORDS; m++) begin
        if (bus_addr == word_at(OFS_CHAN, m)) begin
          for (int k = 0; k < 4; k++) chan[4*m+k] <= bus_wdata[8*k +: CHAN_W];
        end
      end
      if (bus_addr == OFS_GLB) glb_en <= bus_wdata[0];
      if (bus_addr == OFS_HEN) host_en <= bus_wdata[HOST_N-1:0];
      if (bus_addr == OFS_HEN_IDXS && hidx_ok) host_en[HOST_IRQ_BIT] <= 1'b1;
      if (bus_addr == OFS_HEN_IDXC && hidx_ok) host_en[HOST_IRQ_BIT] <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_GLB)    rd_mux = DATA_W'(glb_en);
    if (bus_addr == OFS_HEN)    rd_mux = DATA_W'(host_en);
    if (bus_addr == OFS_WINNER) rd_mux = {~win_valid, {(DATA_W-IDX_W-1){1'b0}}, win_idx};
    for (int w = 0; w < BIT_WORDS; w++) begin
      if (bus_addr == word_at(OFS_STAT_MSK, w)) rd_mux = status[32*w +: 32];
      if (bus_addr == word_at(OFS_EN_MSK, w))   rd_mux = enable[32*w +: 32];
      if (bus_addr == word_at(OFS_POL, w))      rd_mux = pol[32*w +: 32];
      if (bus_addr == word_at(OFS_KIND, w))     rd_mux = kind[32*w +: 32];
    end
    for (int m = 0; m < MAP_WORDS; m++) begin
      if (bus_addr == word_at(OFS_CHAN, m)) begin
        for (int k = 0; k < 4; k++) rd_mux[8*k +: 8] = 8'(chan[4*m+k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & $past(set_vec)) == $past(set_vec)));
  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx_ok && bus_addr == OFS_EN_IDXS) |=> enable[$past(idx_lo)]);
  // R12
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (bus_rvalid == $past(rd)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int CHAN_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [12:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               host_irq
);
  logic [NUM_SRC-1:0]             set_vec, status, enable, pol, kind, cand;
  logic [NUM_SRC-1:0][CHAN_W-1:0] chan;
  logic                           glb_en, win_valid;
  logic [HOST_N-1:0]              host_en;
  logic [IDX_W-1:0]               win_idx;

  irq_sense #(.NUM_SRC(NUM_SRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .pol(pol), .kind(kind), .set_vec(set_vec)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .set_vec(set_vec), .win_valid(win_valid), .win_idx(win_idx),
    .status(status), .enable(enable), .pol(pol), .kind(kind), .chan(chan),
    .glb_en(glb_en), .host_en(host_en)
  );

  assign cand = status & enable;

  irq_arbiter #(.NUM_SRC(NUM_SRC), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand), .chan(chan),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  assign host_irq = glb_en & host_en[HOST_IRQ_BIT] & win_valid;

  // R10
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !host_irq);
  // R10
  host_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (|(status & enable)));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, host_irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_in(src),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .host_irq(host_irq)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [12:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (host_irq !== e) begin
      errors++;
      $display("FAIL %s host_irq actual %0b expected %0b", tag, host_irq, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected read data actual %08h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s read actual %08h expected %08h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
    end
  end

  initial begin
    src[41] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R1");
    bus_rd(13'h080, 32'h8000_0000, "R1");
    bus_rd(13'h380, 32'h0, "R1");
    bus_rd(13'h1500, 32'h0, "R1");
    bus_rd(13'hD00, 32'h0, "R1");

    // configure: high/rising everywhere except line 41 falling; lines 40,41 edge
    bus_wr(13'hD00, 32'hFFFF_FFFF);
    bus_wr(13'hD04, 32'hFFFF_FDFF);
    bus_wr(13'hD84, 32'h0000_0300);
    settle();
    bus_wr(13'h280, 32'hFFFF_FFFF);
    bus_wr(13'h284, 32'hFFFF_FFFF);
    bus_rd(13'h280, 32'h0, "R7");
    bus_rd(13'h284, 32'h0, "R7");
    bus_rd(13'hD04, 32'hFFFF_FDFF, "R2");
    bus_rd(13'hD84, 32'h0000_0300, "R2");

    // R3 level line 5
    src[5] = 1'b1; settle();
    bus_rd(13'h280, 32'h20, "R3");
    bus_wr(13'h024, 32'd5);
    bus_rd(13'h280, 32'h20, "R3");
    src[5] = 1'b0; settle();
    bus_wr(13'h024, 32'd5);
    bus_rd(13'h280, 32'h0, "R3");

    // R4 rising edge line 40, falling edge line 41
    src[40] = 1'b1; settle();
    src[40] = 1'b0; settle();
    bus_rd(13'h284, 32'h100, "R4");
    src[41] = 1'b0; settle();
    bus_rd(13'h284, 32'h300, "R4");

    // R5 indexed status clear
    bus_wr(13'h024, 32'd40);
    bus_rd(13'h284, 32'h200, "R5");
    bus_wr(13'h024, 32'd100);
    bus_rd(13'h284, 32'h200, "R5");

    // R6 indexed enables
    bus_wr(13'h028, 32'd41);
    bus_wr(13'h028, 32'd3);
    bus_rd(13'h380, 32'h8, "R6");
    bus_rd(13'h384, 32'h200, "R6");
    bus_wr(13'h02C, 32'd3);
    bus_rd(13'h380, 32'h0, "R6");
    bus_rd(13'h028, 32'h0, "R12");

    // R10 output gating
    chk_irq(1'b0, "R10");
    bus_wr(13'h010, 32'd1);
    chk_irq(1'b0, "R10");
    bus_wr(13'h034, 32'd1);
    chk_irq(1'b1, "R10");
    bus_rd(13'h1500, 32'h2, "R11");
    bus_rd(13'h010, 32'h1, "R10");
    bus_rd(13'h080, 32'd41, "R9");

    // R9 / R8 priority by channel then number
    src[5] = 1'b1; settle();
    bus_wr(13'h028, 32'd5);
    bus_rd(13'h080, 32'd5, "R9");
    bus_wr(13'h404, 32'h0000_0300);
    bus_rd(13'h080, 32'd41, "R9");
    bus_rd(13'h404, 32'h0000_0300, "R8");
    bus_wr(13'h428, 32'h0000_0700);
    bus_rd(13'h080, 32'd5, "R9");
    bus_wr(13'h380, 32'h20);
    bus_rd(13'h080, 32'd41, "R7");
    bus_rd(13'h380, 32'h0, "R7");
    bus_rd(13'h280, 32'h20, "R7");

    // R11 host enable index clear and direct word
    bus_wr(13'h038, 32'd1);
    chk_irq(1'b0, "R11");
    bus_rd(13'h1500, 32'h0, "R11");
    bus_wr(13'h1500, 32'h2);
    chk_irq(1'b1, "R11");

    // R12 unmapped accesses
    bus_wr(13'h0600, 32'hFFFF_FFFF);
    bus_rd(13'h0600, 32'h0, "R12");
    bus_rd(13'h010, 32'h1, "R12");
    chk_irq(1'b1, "R12");

    bus_wr(13'h384, 32'h200);
    chk_irq(1'b0, "R9");
    bus_rd(13'h080, 32'h8000_0000, "R9");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule